// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a synthesizable behavioural model of a synchronous static RAM with an 18-bit data word and a flow-through read path. Addresses, chip enables, burst controls, write enables and write data are all taken on the rising clock edge. Read data comes straight from the array through combinational logic, so a word is available in the same cycle its address was registered. A four-beat burst therefore reads as 2-1-1-1: one cycle to present the address, then one word per cycle.

A burst starts on either of two address strobes: one meant for a processor and one meant for a cache controller. The start address is captured, and a 2-bit counter then produces the next three addresses each time the advance input is asserted. A static order input picks either linear order (start plus count, modulo 4) or interleaved order (start XOR count). Writes are controlled per byte lane: a global write stores the whole word, or a lane-write enable together with per-lane selects stores only chosen lanes. An output enable gates the read result without any clock, and a sleep input blocks all access. In place of a tristate bus the model has separate data-in and data-out ports plus a data-out valid flag. The array depth is a parameter and is kept small for simulation.

Top module: `fts_burst_sram`

## Requirements
- R1: While reset is asserted, and until the first address strobe after it, `dout_vld_o` is 0 and `dout_o` is all zeros.
- R2: The address and the chip enables are captured only on an edge where `ads_proc_n_i` or `ads_ctrl_n_i` is low. On an edge with both strobes high and `adv_n_i` high, the burst address and the read result stay unchanged, whatever `addr_i` does.
- R3: With `ord_i` = 1 (interleaved), beat k of a burst (k = 0..3, counted by edges with `adv_n_i` low) uses address bits [1:0] = start[1:0] XOR k. The upper address bits do not change.
- R4: With `ord_i` = 0 (linear), beat k uses address bits [1:0] = (start[1:0] + k) mod 4. A fifth advance wraps back to the start address.
- R5: The device is selected only if `ce1_n_i` = 0, `ce2_i` = 1 and `ce3_n_i` = 0 on the strobe edge. The values are held until the next strobe. When it is deselected, no lane is written and `dout_vld_o` stays 0.
- R6: `gw_n_i` = 0 on a write cycle stores all 18 bits, whatever `bwe_n_i` and `bw_n_i` are.
- R7: With `gw_n_i` = 1 and `bwe_n_i` = 0, lane i is stored only if `bw_n_i[i]` = 0. Lane 0 is bits 8:0 and lane 1 is bits 17:9, and the other lane keeps its contents. If no lane is selected, the cycle is a read.
- R8: An edge with `ads_proc_n_i` = 0 is always a read, even if the write enables are active.
- R9: A write happens only on an edge with `ads_ctrl_n_i` = 0 (and `ads_proc_n_i` = 1), or on an advance edge. A hold edge with the write enables active writes nothing.
- R10: `oe_n_i` = 1 forces `dout_vld_o` to 0 and `dout_o` to zero at once, with no clock edge.
- R11: On a read edge, `dout_o` shows the addressed word with `dout_vld_o` = 1 within the same clock cycle, with no added register stage.
- R12: While `sleep_i` = 1, `dout_vld_o` is 0 at once and no edge loads, advances or writes.
- R13: After a write edge, `dout_vld_o` is 0 until the next read edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| addr_i | input | ADDR_W (6) | Word address, captured on strobe edges |
| din_i | input | 18 | Write data |
| ce1_n_i | input | 1 | Primary chip enable, active low |
| ce2_i | input | 1 | Depth-expansion enable, active high |
| ce3_n_i | input | 1 | Depth-expansion enable, active low |
| ads_proc_n_i | input | 1 | Processor address strobe, active low, always reads |
| ads_ctrl_n_i | input | 1 | Controller address strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| gw_n_i | input | 1 | Global write of all lanes, active low |
| bwe_n_i | input | 1 | Lane-write enable, active low |
| bw_n_i | input | 2 | Per-lane write selects, active low |
| ord_i | input | 1 | Burst order: 1 interleaved, 0 linear |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Sleep, blocks access and output |
| dout_o | output | 18 | Read data, zero when not valid |
| dout_vld_o | output | 1 | Read data valid |

## Verification
The bench writes a burst five times over so that the linear counter wraps, then reads the same words in both orders. A counter that failed to wrap would write a fifth address, and an order with the wrong XOR/add selection would return the wrong words. It applies the write enables on processor-strobe and hold cycles, where a decoder that wrote would corrupt a word that is read back later. Partial lane writes followed by reads catch a swapped lane or a clobbered neighbour lane. It also tests a controller strobe with no lane selected, which must read. Deselect, sleep and output-enable tests are run, including a write under each blocking condition followed by a read back. These catch enables that are sampled on every edge instead of held from the strobe, and an output enable that waits for a clock.

// File: rtl/fts_pkg.sv
`timescale 1ns/1ps
package fts_pkg;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_ord_e;

  typedef enum logic [2:0] {
    CYC_HOLD,
    CYC_SLEEP,
    CYC_LOAD_RD,
    CYC_LOAD_WR,
    CYC_STEP_RD,
    CYC_STEP_WR
  } cyc_kind_e;

  // Low two address bits for beat cnt of a burst that started at start.
  function automatic logic [1:0] beat_low(input logic [1:0] start,
                                          input logic [1:0] cnt,
                                          input burst_ord_e ord);
    logic [1:0] res;
    if (ord == ORD_INTERLEAVE) res = start ^ cnt;
    else                       res = start + cnt;
    return res;
  endfunction

endpackage

// File: rtl/fts_rst_sync.sv
`timescale 1ns/1ps
module fts_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/fts_ctrl.sv
`timescale 1ns/1ps
module fts_ctrl
  import fts_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ads_proc_n_i,
  input  logic             ads_ctrl_n_i,
  input  logic             adv_n_i,
  input  logic             ce1_n_i,
  input  logic             ce2_i,
  input  logic             ce3_n_i,
  input  logic             gw_n_i,
  input  logic             bwe_n_i,
  input  logic [LANES-1:0] bw_n_i,
  input  logic             sleep_i,
  output logic             load_o,
  output logic             step_o,
  output logic [LANES-1:0] lane_we_o,
  output logic             sel_o,
  output logic             rd_o
);
  logic             sel_q, sel_n;
  logic             rd_q, rd_n;
  logic             upd_en;
  logic             ce_ok;
  logic [LANES-1:0] lane_mask;
  logic             wr_req;
  cyc_kind_e        kind;

  // Cycle decode
  always_comb begin
    ce_ok = !ce1_n_i && ce2_i && !ce3_n_i;
    if (!gw_n_i)       lane_mask = '1;
    else if (!bwe_n_i) lane_mask = ~bw_n_i;
    else               lane_mask = '0;
    wr_req = |lane_mask;

    if (sleep_i)
      kind = CYC_SLEEP;
    else if (!ads_proc_n_i)
      kind = CYC_LOAD_RD;
    else if (!ads_ctrl_n_i)
      kind = wr_req ? CYC_LOAD_WR : CYC_LOAD_RD;
    else if (!adv_n_i)
      kind = wr_req ? CYC_STEP_WR : CYC_STEP_RD;
    else
      kind = CYC_HOLD;
  end

  // Next state
  always_comb begin
    load_o = (kind == CYC_LOAD_RD) || (kind == CYC_LOAD_WR);
    step_o = (kind == CYC_STEP_RD) || (kind == CYC_STEP_WR);
    upd_en = load_o || step_o;
    sel_n  = load_o ? ce_ok : sel_q;
    rd_n   = (kind == CYC_LOAD_RD) || (kind == CYC_STEP_RD);
    if ((kind == CYC_LOAD_WR || kind == CYC_STEP_WR) && sel_n)
      lane_we_o = lane_mask;
    else
      lane_we_o = '0;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      rd_q  <= 1'b0;
    end else if (upd_en) begin
      sel_q <= sel_n;
      rd_q  <= rd_n;
    end
  end

  assign sel_o = sel_q;
  assign rd_o  = rd_q;

  AST_PROC_STROBE_READS: assert property (@(posedge clk) disable iff (!rst_n)
    !ads_proc_n_i |-> (lane_we_o == '0)); // R8
  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (ads_proc_n_i && ads_ctrl_n_i && adv_n_i) |-> (lane_we_o == '0)); // R9
  AST_SLEEP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |=> ($stable(sel_q) && $stable(rd_q))); // R12
  AST_SELECT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_o |=> $stable(sel_q)); // R5
  AST_DESEL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_o && !sel_q) |-> (lane_we_o == '0)); // R5
endmodule

// File: rtl/fts_burst_addr.sv
`timescale 1ns/1ps
module fts_burst_addr
  import fts_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  burst_ord_e        ord_i,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic [ADDR_W-1:0] nxt_addr_o
);
  localparam int CNT_W = 2;

  logic [ADDR_W-1:0] base_q, base_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              upd_en;

  // Next state
  always_comb begin
    upd_en = load_i || step_i;
    base_n = load_i ? addr_i : base_q;
    if (load_i)      cnt_n = '0;
    else if (step_i) cnt_n = cnt_q + 2'd1;
    else             cnt_n = cnt_q;
    nxt_addr_o = {base_n[ADDR_W-1:CNT_W], beat_low(base_n[CNT_W-1:0], cnt_n, ord_i)};
    cur_addr_o = {base_q[ADDR_W-1:CNT_W], beat_low(base_q[CNT_W-1:0], cnt_q, ord_i)};
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (upd_en) begin
      base_q <= base_n;
      cnt_q  <= cnt_n;
    end
  end

  AST_LOAD_CAPTURES: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == '0 && base_q == $past(addr_i))); // R2
  AST_HOLD_KEEPS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !step_i) |=> ($stable(base_q) && $stable(cnt_q))); // R2
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> (cnt_q == $past(cnt_q) + 2'd1)); // R4
  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> (cur_addr_o[ADDR_W-1:CNT_W] == $past(cur_addr_o[ADDR_W-1:CNT_W]))); // R3
endmodule

// File: rtl/fts_lane_array.sv
`timescale 1ns/1ps
module fts_lane_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        we_i,
  input  logic [ADDR_W-1:0]       waddr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0]       raddr_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we_i[g]) mem[waddr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end

    assign rdata_o[g*LANE_W +: LANE_W] = mem[raddr_i];
  end
endmodule

// File: rtl/fts_burst_sram.sv
`timescale 1ns/1ps
module fts_burst_sram
  import fts_pkg::*;
#(
  parameter int  ADDR_W = 6,
  parameter int  LANES  = 2,
  parameter int  LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] din_i,
  input  logic              ce1_n_i,
  input  logic              ce2_i,
  input  logic              ce3_n_i,
  input  logic              ads_proc_n_i,
  input  logic              ads_ctrl_n_i,
  input  logic              adv_n_i,
  input  logic              gw_n_i,
  input  logic              bwe_n_i,
  input  logic [LANES-1:0]  bw_n_i,
  input  logic              ord_i,
  input  logic              oe_n_i,
  input  logic              sleep_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              dout_vld_o
);
  logic              rst_sync_n;
  logic              load, step;
  logic [LANES-1:0]  lane_we;
  logic              sel, rd;
  logic [ADDR_W-1:0] cur_addr, nxt_addr;
  logic [DATA_W-1:0] rdata;
  burst_ord_e        ord;

  assign ord = burst_ord_e'(ord_i);

  fts_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fts_ctrl #(.LANES(LANES)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .ads_proc_n_i (ads_proc_n_i),
    .ads_ctrl_n_i (ads_ctrl_n_i),
    .adv_n_i      (adv_n_i),
    .ce1_n_i      (ce1_n_i),
    .ce2_i        (ce2_i),
    .ce3_n_i      (ce3_n_i),
    .gw_n_i       (gw_n_i),
    .bwe_n_i      (bwe_n_i),
    .bw_n_i       (bw_n_i),
    .sleep_i      (sleep_i),
    .load_o       (load),
    .step_o       (step),
    .lane_we_o    (lane_we),
    .sel_o        (sel),
    .rd_o         (rd)
  );

  fts_burst_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load_i     (load),
    .step_i     (step),
    .addr_i     (addr_i),
    .ord_i      (ord),
    .cur_addr_o (cur_addr),
    .nxt_addr_o (nxt_addr)
  );

  fts_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk     (clk),
    .we_i    (lane_we),
    .waddr_i (nxt_addr),
    .wdata_i (din_i),
    .raddr_i (cur_addr),
    .rdata_o (rdata)
  );

  // Flow-through output: no register between array and port
  always_comb begin
    dout_vld_o = sel && rd && !oe_n_i && !sleep_i;
    dout_o     = dout_vld_o ? rdata : '0;
  end

  AST_WRITE_QUIETS_OUTPUT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lane_we != '0) |=> !dout_vld_o); // R13
  AST_READ_SHOWS_AT_ONCE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (load && !ads_proc_n_i && !ce1_n_i && ce2_i && !ce3_n_i) |=>
      (dout_vld_o || oe_n_i || sleep_i)); // R11
endmodule

// File: tb/sim_fts_burst_sram.sv
`timescale 1ns/1ps
module sim_fts_burst_sram;
  localparam int AW = 6;
  localparam int DW = 18;

  logic          clk, rst_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] din;
  logic ce1_n, ce2, ce3_n, ads_p_n, ads_c_n, adv_n, gw_n, bwe_n, ord, oe_n, sleep;
  logic [1:0]    bw_n;
  logic [DW-1:0] dout;
  logic          dout_vld;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  fts_burst_sram u0 (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .din_i(din),
    .ce1_n_i(ce1_n), .ce2_i(ce2), .ce3_n_i(ce3_n),
    .ads_proc_n_i(ads_p_n), .ads_ctrl_n_i(ads_c_n), .adv_n_i(adv_n),
    .gw_n_i(gw_n), .bwe_n_i(bwe_n), .bw_n_i(bw_n), .ord_i(ord),
    .oe_n_i(oe_n), .sleep_i(sleep), .dout_o(dout), .dout_vld_o(dout_vld)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Vector fields are active high: p/c strobe, a advance, gw, bwe, bw lane picks
  typedef struct packed {
    logic          p, c, a, gw, bwe;
    logic [1:0]    bw;
    logic          md;
    logic [AW-1:0] ad;
    logic [DW-1:0] di;
    logic          ev;
    logic [DW-1:0] ed;
    logic [3:0]    rq;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b1,1'b0,1'b1,1'b0,2'b00,1'b0,6'd8 ,18'h00101,1'b0,18'h00000,4'd13}, // R13 write, no valid
    '{1'b0,1'b0,1'b1,1'b1,1'b0,2'b00,1'b0,6'd0 ,18'h00202,1'b0,18'h00000,4'd13}, // addr 9
    '{1'b0,1'b0,1'b1,1'b1,1'b0,2'b00,1'b0,6'd0 ,18'h00303,1'b0,18'h00000,4'd13}, // addr 10
    '{1'b0,1'b0,1'b1,1'b1,1'b0,2'b00,1'b0,6'd0 ,18'h00404,1'b0,18'h00000,4'd13}, // addr 11
    '{1'b0,1'b0,1'b1,1'b1,1'b0,2'b00,1'b0,6'd0 ,18'h00505,1'b0,18'h00000,4'd4 }, // R4 wrap to 8
    '{1'b1,1'b0,1'b0,1'b0,1'b0,2'b00,1'b0,6'd9 ,18'h00000,1'b1,18'h00202,4'd11}, // R11 same-cycle read
    '{1'b0,1'b0,1'b1,1'b0,1'b0,2'b00,1'b0,6'd0 ,18'h00000,1'b1,18'h00303,4'd4 }, // R4 -> 10
    '{1'b0,1'b0,1'b1,1'b0,1'b0,2'b00,1'b0,6'd0 ,18'h00000,1'b1,18'h00404,4'd4 }, // R4 -> 11
    '{1'b0,1'b0,1'b1,1'b0,1'b0,2'b00,1'b0,6'd0 ,18'h00000,1'b1,18'h00505,4'd4 }, // R4 -> 8
    '{1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,1'b0,6'd3 ,18'h00000,1'b1,18'h00505,4'd2 }, // R2 hold
    '{1'b1,1'b0,1'b0,1'b0,1'b0,2'b00,1'b1,6'd10,18'h00000,1'b1,18'h00303,4'd3 }, // R3 start 2
    '{1'b0,1'b0,1'b1,1'b0,1'b0,2'b00,1'b1,6'd0 ,18'h00000,1'b1,18'h00404,4'd3 }, // R3 -> 11
    '{1'b0,1'b0,1'b1,1'b0,1'b0,2'b00,1'b1,6'd0 ,18'h00000,1'b1,18'h00505,4'd3 }, // R3 -> 8
    '{1'b0,1'b0,1'b1,1'b0,1'b0,2'b00,1'b1,6'd0 ,18'h00000,1'b1,18'h00202,4'd3 }, // R3 -> 9
    '{1'b0,1'b1,1'b0,1'b0,1'b1,2'b01,1'b0,6'd9 ,18'h3FFFF,1'b0,18'h00000,4'd7 }, // R7 lane 0 write
    '{1'b1,1'b0,1'b0,1'b0,1'b0,2'b00,1'b0,6'd9 ,18'h00000,1'b1,18'h003FF,4'd7 }, // R7
    '{1'b0,1'b1,1'b0,1'b0,1'b1,2'b10,1'b0,6'd9 ,18'h00000,1'b0,18'h00000,4'd7 }, // R7 lane 1 write
    '{1'b1,1'b0,1'b0,1'b0,1'b0,2'b00,1'b0,6'd9 ,18'h00000,1'b1,18'h001FF,4'd7 }, // R7
    '{1'b1,1'b0,1'b0,1'b1,1'b0,2'b00,1'b0,6'd10,18'h3FFFF,1'b1,18'h00303,4'd8 }, // R8 reads
    '{1'b1,1'b0,1'b0,1'b0,1'b0,2'b00,1'b0,6'd10,18'h00000,1'b1,18'h00303,4'd8 }, // R8 unchanged
    '{1'b0,1'b0,1'b0,1'b1,1'b0,2'b00,1'b0,6'd10,18'h3FFFF,1'b1,18'h00303,4'd9 }, // R9 hold no write
    '{1'b1,1'b0,1'b0,1'b0,1'b0,2'b00,1'b0,6'd10,18'h00000,1'b1,18'h00303,4'd9 }, // R9
    '{1'b0,1'b1,1'b0,1'b1,1'b1,2'b00,1'b0,6'd12,18'h2AAAA,1'b0,18'h00000,4'd6 }, // R6 global write
    '{1'b1,1'b0,1'b0,1'b0,1'b0,2'b00,1'b0,6'd12,18'h00000,1'b1,18'h2AAAA,4'd6 }, // R6
    '{1'b0,1'b1,1'b0,1'b0,1'b1,2'b00,1'b0,6'd12,18'h00000,1'b1,18'h2AAAA,4'd7 }, // R7 no lane = read
    '{1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,1'b0,6'd0 ,18'h00000,1'b1,18'h2AAAA,4'd2 }  // R2 addr ignored
  };

  task automatic check(input string req, input logic [DW-1:0] got_d, input logic got_v,
                       input logic [DW-1:0] exp_d, input logic exp_v);
    checks++;
    if (got_d !== exp_d || got_v !== exp_v) begin
      fails++;
      $display("FAIL %s: got vld=%0b dout=%05h, expected vld=%0b dout=%05h",
               req, got_v, got_d, exp_v, exp_d);
    end
  endtask

  task automatic idle();
    ads_p_n = 1'b1; ads_c_n = 1'b1; adv_n = 1'b1;
    gw_n = 1'b1; bwe_n = 1'b1; bw_n = 2'b11;
  endtask

  // Drive at negedge, take the edge, sample 5 ns later
  task automatic cycle();
    @(posedge clk);
    #5;
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; addr = '0; din = '0;
    ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
    ord = 1'b0; oe_n = 1'b0; sleep = 1'b0;
    idle();
    repeat (3) @(posedge clk);
    #5;
    check("R1 in reset", dout, dout_vld, '0, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) cycle();
    check("R1 after reset", dout, dout_vld, '0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      ads_p_n = ~TBL[i].p; ads_c_n = ~TBL[i].c; adv_n = ~TBL[i].a;
      gw_n = ~TBL[i].gw; bwe_n = ~TBL[i].bwe; bw_n = ~TBL[i].bw;
      ord = TBL[i].md; addr = TBL[i].ad; din = TBL[i].di;
      cycle();
      check($sformatf("R%0d vector %0d", TBL[i].rq, i), dout, dout_vld, TBL[i].ed, TBL[i].ev);
    end

    // R10: output enable without a clock edge
    @(negedge clk); idle();
    oe_n = 1'b1; #2;
    check("R10 oe off", dout, dout_vld, '0, 1'b0);
    oe_n = 1'b0; #2;
    check("R10 oe on", dout, dout_vld, 18'h2AAAA, 1'b1);

    // R12: sleep blocks output and writes
    sleep = 1'b1; #2;
    check("R12 sleep output", dout, dout_vld, '0, 1'b0);
    @(negedge clk); ads_c_n = 1'b0; gw_n = 1'b0; addr = 6'd12; din = 18'h00000;
    cycle();
    check("R12 sleep edge", dout, dout_vld, '0, 1'b0);
    @(negedge clk); idle(); sleep = 1'b0; ads_p_n = 1'b0; addr = 6'd12;
    cycle();
    check("R12 write blocked", dout, dout_vld, 18'h2AAAA, 1'b1);

    // R5: deselect cases
    @(negedge clk); idle(); ads_p_n = 1'b0; ce2 = 1'b0;
    cycle();
    check("R5 ce2 low", dout, dout_vld, '0, 1'b0);
    @(negedge clk); idle(); ads_c_n = 1'b0; gw_n = 1'b0; ce2 = 1'b1; ce1_n = 1'b1; din = 18'h15555;
    cycle();
    check("R5 ce1 high write", dout, dout_vld, '0, 1'b0);
    @(negedge clk); idle(); ce1_n = 1'b0;
    cycle();
    check("R5 enables held", dout, dout_vld, '0, 1'b0);
    @(negedge clk); idle(); ads_p_n = 1'b0; ce3_n = 1'b1;
    cycle();
    check("R5 ce3 high", dout, dout_vld, '0, 1'b0);
    @(negedge clk); idle(); ads_p_n = 1'b0; ce3_n = 1'b0;
    cycle();
    check("R5 deselected write ignored", dout, dout_vld, 18'h2AAAA, 1'b1);

    // R13: write via advance ends valid output
    @(negedge clk); idle(); adv_n = 1'b0; bwe_n = 1'b0; bw_n = 2'b10; din = 18'h00000;
    cycle();
    check("R13 advance write", dout, dout_vld, '0, 1'b0);

    // R1: asynchronous reset clears output at once
    @(negedge clk); idle(); ads_p_n = 1'b0; addr = 6'd12;
    cycle();
    rst_n = 1'b0; #2;
    check("R1 async reset", dout, dout_vld, '0, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule